// File: doc/BRIEF.md
# RTC Alarm Compare and Interrupt

This block watches the calendar time of a real-time clock and raises an alarm when that time reaches a value that software has programmed. Software sets four alarm fields: minute, hour, day of month and day of week. Each field has its own exclude bit. An excluded field takes no part in the comparison. The current time comes in as BCD values together with a one-cycle pulse each time the minute advances. The comparison is made only on that pulse.

A successful comparison sets a sticky alarm flag. The flag stays set until software writes zero to it. The interrupt output is an enable for an open-drain driver: it pulls the line low while both the flag and an interrupt-enable bit are set, and releases the line otherwise.

All state is reached through a byte-wide register port. Writes are strobed. Read data is combinational from the address. The timekeeping counters, the host serial bus, the countdown timer and the clock output sit outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the alarm flag and the interrupt enable are 0, every exclude bit is 1 (so each alarm register reads 80h), and irqDriveLow is 0.
- R2: Register map and read back:
  - 09h holds the minute alarm in bits 6:0.
  - 0Ah holds the hour alarm in bits 5:0.
  - 0Bh holds the day alarm in bits 5:0.
  - 0Ch holds the weekday alarm in bits 2:0.
  - Bit 7 of each of these four registers is its exclude bit. Their other bits are stored and read back as 0.
  - At 01h, bit 3 is the alarm flag and bit 1 is the interrupt enable. All other bits of 01h read 0.
- R3: On a minuteTick pulse, the alarm flag is set when every field whose exclude bit is 0 equals the corresponding BCD time input, compared bit for bit.
- R4: When all four exclude bits are 1, the alarm flag is never set.
- R5: A matching time without a minuteTick pulse does not set the alarm flag.
- R6: The alarm flag is sticky. Writing 01h with bit 3 = 0 clears it. Writing 01h with bit 3 = 1 leaves it unchanged. Every write to 01h loads the interrupt enable from bit 1.
- R7: A match that is still present at the next minuteTick does not set the flag again once it has been cleared. A match that follows a non-matching minuteTick does set it.
- R8: irqDriveLow is 1 exactly while the alarm flag and the interrupt enable are both 1.
- R9: When a flag-setting minuteTick and a write that clears the flag fall in the same cycle, the flag ends up set.
- R10: Writes to any address other than 01h and 09h–0Ch change nothing, and reads of those addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register address for both reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| timeMin | input | 7 | Current minute, BCD |
| timeHour | input | 6 | Current hour, BCD |
| timeDay | input | 6 | Current day of month, BCD |
| timeWday | input | 3 | Current weekday, 0 to 6 |
| minuteTick | input | 1 | One-cycle pulse when the minute advances |
| irqDriveLow | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the control register at 01h and the alarm registers starting at 09h. With these values the unused addresses between and beyond the registers are reachable, so the ignore rule can be checked at both 05h and 0Dh. The bench can also present the time directly, with or without a minute pulse. This makes the following cases reachable in a handful of cycles:
- a match held across several pulses,
- a match that disappears and then returns,
- a clear that coincides with a new match.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NUM_FIELDS = 4;

  localparam int FIELD_MIN  = 0;
  localparam int FIELD_HOUR = 1;
  localparam int FIELD_DAY  = 2;
  localparam int FIELD_WDAY = 3;

  localparam int CTRL_FLAG_BIT = 3;
  localparam int CTRL_IEN_BIT  = 1;
  localparam int EXCL_BIT      = 7;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrAlarm;
    logic                  wrCtrl;
    logic                  setFlag;
    logic                  clrFlag;
  } alarmStrobes_t;

  // Bits that are kept in each alarm register; all others read 0.
  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      FIELD_MIN:  fieldMask = 8'hFF;
      FIELD_HOUR: fieldMask = 8'hBF;
      FIELD_DAY:  fieldMask = 8'hBF;
      default:    fieldMask = 8'h87;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] ALARM_BASE = ADDR_W'(9)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              minuteTick,
  input  logic              fullMatch,
  output alarmStrobes_t     strobes
);

  logic lastMatch;
  logic [NUM_FIELDS-1:0] wrAlarm;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
      localparam logic [ADDR_W-1:0] FIELD_ADDR = ALARM_BASE + ADDR_W'(gi);
      assign wrAlarm[gi] = regWrEn && (regAddr == FIELD_ADDR);
    end
  endgenerate

  // Match state seen at the most recent minute pulse; a new event needs
  // a pulse where the match is present after one where it was absent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lastMatch <= 1'b0;
    else if (minuteTick) lastMatch <= fullMatch;
  end

  always_comb begin
    strobes.wrAlarm = wrAlarm;
    strobes.wrCtrl  = regWrEn && (regAddr == CTRL_ADDR);
    strobes.setFlag = minuteTick && fullMatch && !lastMatch;
    strobes.clrFlag = strobes.wrCtrl && !regWrData[CTRL_FLAG_BIT];
  end

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] ALARM_BASE = ADDR_W'(9)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  alarmStrobes_t         strobes,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [7:0]            regWrData,
  input  logic [6:0]            timeMin,
  input  logic [5:0]            timeHour,
  input  logic [5:0]            timeDay,
  input  logic [2:0]            timeWday,
  output logic                  fullMatch,
  output logic                  alarmFlag,
  output logic                  irqEnable,
  output logic [NUM_FIELDS-1:0] exclBits,
  output logic [7:0]            regRdData
);

  logic [7:0] alarmReg [NUM_FIELDS];
  logic [7:0] timeVec  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldOk;

  assign timeVec[FIELD_MIN]  = {1'b0, timeMin};
  assign timeVec[FIELD_HOUR] = {2'b0, timeHour};
  assign timeVec[FIELD_DAY]  = {2'b0, timeDay};
  assign timeVec[FIELD_WDAY] = {5'b0, timeWday};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIELDS; i++) alarmReg[i] <= 8'h80;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (strobes.wrAlarm[i]) alarmReg[i] <= regWrData & fieldMask(i);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
      assign exclBits[gi] = alarmReg[gi][EXCL_BIT];
      assign fieldOk[gi]  = exclBits[gi] ||
                            (alarmReg[gi][6:0] == timeVec[gi][6:0]);
    end
  endgenerate

  assign fullMatch = (&fieldOk) && !(&exclBits);

  // A set in the same cycle as a clearing write takes precedence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarmFlag <= 1'b0;
      irqEnable <= 1'b0;
    end else begin
      if (strobes.setFlag)      alarmFlag <= 1'b1;
      else if (strobes.clrFlag) alarmFlag <= 1'b0;
      if (strobes.wrCtrl)       irqEnable <= regWrData[CTRL_IEN_BIT];
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (regAddr == CTRL_ADDR) begin
      regRdData[CTRL_FLAG_BIT] = alarmFlag;
      regRdData[CTRL_IEN_BIT]  = irqEnable;
    end
    for (int i = 0; i < NUM_FIELDS; i++)
      if (regAddr == ALARM_BASE + ADDR_W'(i)) regRdData = alarmReg[i];
  end

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] ALARM_BASE = ADDR_W'(9)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [6:0]        timeMin,
  input  logic [5:0]        timeHour,
  input  logic [5:0]        timeDay,
  input  logic [2:0]        timeWday,
  input  logic              minuteTick,
  output logic              irqDriveLow
);

  alarmStrobes_t         strobes;
  logic                  fullMatch;
  logic                  alarmFlag;
  logic                  irqEnable;
  logic [NUM_FIELDS-1:0] exclBits;

  rtc_alarm_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ALARM_BASE(ALARM_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .minuteTick(minuteTick),
    .fullMatch(fullMatch), .strobes(strobes)
  );

  rtc_alarm_dp #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ALARM_BASE(ALARM_BASE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regAddr(regAddr),
    .regWrData(regWrData), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeWday(timeWday), .fullMatch(fullMatch),
    .alarmFlag(alarmFlag), .irqEnable(irqEnable), .exclBits(exclBits),
    .regRdData(regRdData)
  );

  assign irqDriveLow = alarmFlag && irqEnable;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              minuteTick,
  input logic              irqDriveLow,
  input logic              alarmFlag,
  input logic [3:0]        exclBits,
  input logic              setFlag
);

  // R5: the flag only rises right after a minute pulse
  p_flag_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> $past(minuteTick));

  // R4: nothing rises while every field is excluded
  p_all_excluded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> !(&$past(exclBits)));

  // R6: the flag falls only through a clearing control write
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarmFlag) |-> $past(regWrEn && regAddr == CTRL_ADDR && !regWrData[3]));

  // R9: a set strobe always leaves the flag high, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    setFlag |=> alarmFlag);

  // R8: the line can only start being driven after a tick or control write
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqDriveLow) |-> ($past(minuteTick) || $past(regWrEn && regAddr == CTRL_ADDR)));

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .minuteTick(minuteTick), .irqDriveLow(irqDriveLow),
  .alarmFlag(alarmFlag), .exclBits(exclBits), .setFlag(strobes.setFlag)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [6:0] timeMin = 7'h00;
  logic [5:0] timeHour = 6'h00;
  logic [5:0] timeDay = 6'h01;
  logic [2:0] timeWday = 3'd0;
  logic       minuteTick = 1'b0;
  logic       irqDriveLow;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timeMin(timeMin),
    .timeHour(timeHour), .timeDay(timeDay), .timeWday(timeWday),
    .minuteTick(minuteTick), .irqDriveLow(irqDriveLow)
  );

  typedef struct packed {
    logic [7:0] aMin, aHour, aDay, aWday;
    logic [6:0] tMin;
    logic [5:0] tHour, tDay;
    logic [2:0] tWday;
    logic       expFlag;
  } vec_t;

  // alarm min/hour/day/wday, time min/hour/day/wday, expected flag (R3/R4)
  localparam vec_t VECS [8] = '{
    '{8'h30, 8'h12, 8'h15, 8'h03, 7'h30, 6'h12, 6'h15, 3'd3, 1'b1},
    '{8'h30, 8'h12, 8'h80, 8'h03, 7'h30, 6'h12, 6'h22, 3'd3, 1'b1},
    '{8'h30, 8'h12, 8'h15, 8'h03, 7'h31, 6'h12, 6'h15, 3'd3, 1'b0},
    '{8'h80, 8'h80, 8'h80, 8'h80, 7'h00, 6'h00, 6'h01, 3'd0, 1'b0},
    '{8'h80, 8'h80, 8'h80, 8'h05, 7'h45, 6'h07, 6'h09, 3'd5, 1'b1},
    '{8'h45, 8'h80, 8'h80, 8'h80, 7'h45, 6'h07, 6'h09, 3'd4, 1'b1},
    '{8'h45, 8'h07, 8'h80, 8'h80, 7'h45, 6'h08, 6'h09, 3'd1, 1'b0},
    '{8'h00, 8'h00, 8'h01, 8'h80, 7'h00, 6'h00, 6'h01, 3'd2, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic tick();
    @(negedge clk);
    minuteTick = 1'b1;
    @(negedge clk);
    minuteTick = 1'b0;
  endtask

  task automatic setTime(input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [2:0] w);
    @(negedge clk);
    timeMin = m; timeHour = h; timeDay = d; timeWday = w;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'b0, irqDriveLow}, 8'h00);
    for (int i = 9; i <= 12; i++) begin
      rd(4'(i), v); check("R1 alarm", v, 8'h80);
    end
    rd(4'h1, v); check("R1 ctrl", v, 8'h00);

    // R2 masking of unused bits
    wr(4'h9, 8'hFF); rd(4'h9, v); check("R2 min", v, 8'hFF);
    wr(4'hA, 8'hFF); rd(4'hA, v); check("R2 hour", v, 8'hBF);
    wr(4'hB, 8'hFF); rd(4'hB, v); check("R2 day", v, 8'hBF);
    wr(4'hC, 8'hFF); rd(4'hC, v); check("R2 wday", v, 8'h87);
    wr(4'h1, 8'hF7); rd(4'h1, v); check("R2 ctrl", v, 8'h02);

    // Table walk: R3 and R4, plus R5 before each tick
    foreach (VECS[k]) begin
      wr(4'h9, VECS[k].aMin);  wr(4'hA, VECS[k].aHour);
      wr(4'hB, VECS[k].aDay);  wr(4'hC, VECS[k].aWday);
      setTime(7'h59, 6'h23, 6'h31, 3'd6);
      tick();
      wr(4'h1, 8'h00);
      setTime(VECS[k].tMin, VECS[k].tHour, VECS[k].tDay, VECS[k].tWday);
      repeat (2) @(negedge clk);
      rd(4'h1, v); check("R5 no tick", v, 8'h00);
      tick();
      rd(4'h1, v);
      check(VECS[k].aWday == 8'h80 && VECS[k].aMin == 8'h80 ? "R4 table" : "R3 table",
            v, {4'b0, VECS[k].expFlag, 3'b0});
    end

    // R6 and R8: flag is set here; writing bit 3 = 1 keeps it
    wr(4'h1, 8'h0A); rd(4'h1, v); check("R6 write one", v, 8'h0A);
    check("R8 irq on", {7'b0, irqDriveLow}, 8'h01);
    wr(4'h1, 8'h02); rd(4'h1, v); check("R6 clear", v, 8'h02);
    check("R8 irq off", {7'b0, irqDriveLow}, 8'h00);

    // R7: match persists over the next tick
    tick(); rd(4'h1, v); check("R7 persist", v, 8'h02);
    setTime(7'h01, 6'h00, 6'h01, 3'd2); tick();
    setTime(7'h00, 6'h00, 6'h01, 3'd2); tick();
    rd(4'h1, v); check("R7 rematch", v, 8'h0A);
    check("R8 irq rematch", {7'b0, irqDriveLow}, 8'h01);

    // R8: enable off while flag set
    wr(4'h1, 8'h08); rd(4'h1, v); check("R8 ien off", v, 8'h08);
    check("R8 irq masked", {7'b0, irqDriveLow}, 8'h00);

    // R9: clear and new match in one cycle
    wr(4'h1, 8'h00);
    setTime(7'h01, 6'h00, 6'h01, 3'd2); tick();
    setTime(7'h00, 6'h00, 6'h01, 3'd2);
    @(negedge clk);
    regAddr = 4'h1; regWrData = 8'h00; regWrEn = 1'b1; minuteTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; minuteTick = 1'b0;
    rd(4'h1, v); check("R9 set wins", v, 8'h08);

    // R10: other addresses
    wr(4'h5, 8'hFF); rd(4'h5, v); check("R10 read", v, 8'h00);
    rd(4'h1, v); check("R10 ctrl kept", v, 8'h08);
    rd(4'h9, v); check("R10 min kept", v, 8'h00);
    wr(4'hD, 8'h00); rd(4'hC, v); check("R10 wday kept", v, 8'h80);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule